// File: doc/BRIEF.md
# USB Receive Endpoint Control and Status

This block holds the byte-wide control/status register of one device-mode OUT endpoint and keeps track of the packets behind it. The serial interface engine reports each finished packet, along with its error flag, its DATA0/DATA1 identity and any STALL handshake it has sent. On the CPU side, the block learns when a packet has been read out of the FIFO and how many bytes were taken. From these inputs it decides whether an arriving packet is stored, NAKed, dropped or counted as an overrun. It also keeps the expected data toggle, raises the endpoint interrupt and asks the FIFO to reset its read pointer when a packet is flushed.

The endpoint holds one or two packets, selected by a double-buffer input. It runs in bulk or isochronous mode. An auto-clear option releases a packet by itself once a full maximum-size packet has been read out. Software reads the register on a combinational read port and writes it with a single-cycle write strobe.

Top module: `usb_rx_ep_ctrl`

## Requirements
- R1: After reset, the register reads 0x00, the data toggle is DATA0 (0), and stall_hs, rx_nak, ep_irq and fifo_rd_rst are all 0.
- R2: A stored packet sets RXRDY (bit 0) on the clock edge that takes rx_pkt. On that same edge, ep_irq becomes 1 for exactly one cycle.
- R3: With autoclr set, an unload report whose byte count equals max_pkt_size releases the current packet. A shorter count does not release it, and neither does any count when autoclr is clear.
- R4: A register write with bit 0 at 0 while RXRDY is 1 releases the current packet. Writing 1 to bit 0 has no effect.
- R5: A register write with bit 4 (FLUSH) at 1 while RXRDY is 1 discards exactly one packet and pulses fifo_rd_rst for one cycle. With two packets held, RXRDY stays 1 for the second one, and ep_irq pulses again.
- R6: A FLUSH write while RXRDY is 0 does nothing: no fifo_rd_rst pulse and no change to the register.
- R7: In isochronous mode, DATAERR (bit 3) is set together with RXRDY when the stored packet carried rx_err. It clears as soon as that packet is released.
- R8: In isochronous mode, a packet that finds no free slot sets OVER (bit 2) and is not stored. OVER stays set until a write with bit 2 at 0. In bulk mode, bits 3 and 2 read 0.
- R9: While STALL (bit 5) is 1 and the endpoint is in bulk mode, stall_hs is 1 and arriving packets are not stored. In isochronous mode, stall_hs is 0 whatever STALL holds.
- R10: A stall_sent pulse sets STALLED (bit 6). STALLED stays set until a write with bit 6 at 0.
- R11: In bulk mode, an error-free packet whose rx_data1 equals data_toggle is stored and flips the toggle. A packet with the wrong toggle is dropped and leaves the toggle as it was. A write with bit 7 (CLRDT) at 1 forces the toggle to 0. Bit 7 always reads 0.
- R12: FULL (bit 1) is 1 when every slot is taken: one packet when dbl_buf is 0, two packets when dbl_buf is 1.
- R13: In bulk mode, a valid packet that finds no free slot gives a one-cycle rx_nak pulse. The packet is not stored, the toggle is unchanged and OVER is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| rx_pkt | input | 1 | Serial engine: an OUT packet has ended |
| rx_err | input | 1 | Serial engine: that packet had a CRC or bit-stuff error |
| rx_data1 | input | 1 | Serial engine: the packet was DATA1 (0 means DATA0) |
| stall_sent | input | 1 | Serial engine: a STALL handshake went out |
| unld_done | input | 1 | CPU side: the current packet has been read from the FIFO |
| unld_len | input | MAXP_W | Bytes read with unld_done |
| max_pkt_size | input | MAXP_W | Maximum packet size of the endpoint |
| autoclr | input | 1 | Release the packet automatically on a full-size unload |
| iso_mode | input | 1 | 1 selects isochronous mode, 0 selects bulk mode |
| dbl_buf | input | 1 | 1 allows two packets to be held |
| stall_hs | output | 1 | Answer with a STALL handshake |
| rx_nak | output | 1 | One-cycle pulse: a packet was NAKed |
| data_toggle | output | 1 | Expected data toggle of the next packet |
| ep_irq | output | 1 | One-cycle endpoint interrupt pulse |
| fifo_rd_rst | output | 1 | One-cycle request to reset the FIFO read pointer |

## Verification
Packets are sent in bulk and isochronous mode, with one and with two slots. The tests separate the outcomes "stored", "NAKed because full", "dropped for a wrong toggle", "dropped under STALL" and "overrun". Packets are released in each available way: unload reports shorter than and equal to the maximum size (with auto-clear on and off), manual release writes, and flush writes. This tells a release that counts bytes from one that fires on any unload. Back-to-back flushes with two packets held check that each write takes exactly one packet and re-raises the interrupt. Writes of 0 and 1 to each sticky bit, and a mode change while the error bits are set, show which bits are write-to-clear and which are masked by mode.

// File: rtl/usb_rx_ep_pkg.sv
package usb_rx_ep_pkg;

  // Register bit positions (software decodes these)
  localparam int B_CLRDT   = 7;
  localparam int B_STALLED = 6;
  localparam int B_STALL   = 5;
  localparam int B_FLUSH   = 4;
  localparam int B_DATAERR = 3;
  localparam int B_OVER    = 2;
  localparam int B_FULL    = 1;
  localparam int B_RXRDY   = 0;

  // Number of packet slots available in the chosen buffering mode
  function automatic logic [1:0] slot_cap(input logic dbl);
    return dbl ? 2'd2 : 2'd1;
  endfunction

  // Full-size unload with auto-clear enabled releases the packet
  function automatic logic autoclr_hit(input logic en, input logic [15:0] len,
                                       input logic [15:0] maxp);
    return en && (len == maxp);
  endfunction

  // Bulk toggle check: packet PID must match the expected toggle
  function automatic logic toggle_ok(input logic pid1, input logic expect1);
    return pid1 == expect1;
  endfunction

endpackage

// File: rtl/usb_rx_slot_q.sv
module usb_rx_slot_q
  import usb_rx_ep_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       push_err,
  input  logic       pop,
  input  logic [1:0] cap,
  output logic [1:0] cnt,
  output logic       room,
  output logic       head_err,
  output logic       head_new
);

  logic [1:0]       cnt_q, cnt_n, wr_idx;
  logic [SLOTS-1:0] err_q, err_n;

  assign wr_idx = cnt_q - {1'b0, pop};
  assign cnt_n  = cnt_q + {1'b0, push} - {1'b0, pop};

  always_comb begin
    err_n = err_q;
    if (pop) begin
      for (int i = 0; i < SLOTS - 1; i++) err_n[i] = err_q[i+1];
      err_n[SLOTS-1] = 1'b0;
    end
    if (push) err_n[wr_idx[0]] = push_err;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      err_q <= err_n;
    end
  end

  assign cnt      = cnt_q;
  assign room     = cnt_q < cap;
  assign head_err = err_q[0];
  assign head_new = (cnt_n != 2'd0) && ((cnt_q == 2'd0) || pop);

endmodule

// File: rtl/usb_rx_ep_csr.sv
module usb_rx_ep_csr
  import usb_rx_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       rxrdy,
  input  logic       stall_sent,
  input  logic       over_set,
  output logic       stall_bit,
  output logic       stalled,
  output logic       over,
  output logic       clr_tog,
  output logic       flush_req,
  output logic       rel_req
);

  assign clr_tog   = wr && wdata[B_CLRDT];
  assign flush_req = wr && wdata[B_FLUSH] && rxrdy;
  assign rel_req   = wr && !wdata[B_RXRDY] && rxrdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_bit <= 1'b0;
      stalled   <= 1'b0;
      over      <= 1'b0;
    end else begin
      if (wr) stall_bit <= wdata[B_STALL];
      if (stall_sent)                     stalled <= 1'b1;
      else if (wr && !wdata[B_STALLED])   stalled <= 1'b0;
      if (over_set)                       over <= 1'b1;
      else if (wr && !wdata[B_OVER])      over <= 1'b0;
    end
  end

endmodule

// File: rtl/usb_rx_ep_toggle.sv
module usb_rx_ep_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic tog
);

  always_ff @(posedge clk) begin
    if (!rst_n)   tog <= 1'b0;
    else if (clr) tog <= 1'b0;
    else if (adv) tog <= !tog;
  end

endmodule

// File: rtl/usb_rx_ep_ctrl.sv
module usb_rx_ep_ctrl
  import usb_rx_ep_pkg::*;
#(
  parameter int MAXP_W = 11,
  parameter int SLOTS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              rx_pkt,
  input  logic              rx_err,
  input  logic              rx_data1,
  input  logic              stall_sent,
  input  logic              unld_done,
  input  logic [MAXP_W-1:0] unld_len,
  input  logic [MAXP_W-1:0] max_pkt_size,
  input  logic              autoclr,
  input  logic              iso_mode,
  input  logic              dbl_buf,
  output logic              stall_hs,
  output logic              rx_nak,
  output logic              data_toggle,
  output logic              ep_irq,
  output logic              fifo_rd_rst
);

  // Named internal events (also observed by the checker)
  logic [1:0] cnt;
  logic       room, head_err, head_new, rxrdy;
  logic       stall_bit, stalled, over;
  logic       clr_tog, flush_req, rel_req, auto_rel;
  logic       pkt_valid, accept, nak_ev, over_ev, pop, tog_adv;

  assign rxrdy     = cnt != 2'd0;
  assign stall_hs  = stall_bit && !iso_mode;

  // Bulk: error-free and toggle-matched packets are candidates; iso: all are
  assign pkt_valid = rx_pkt && !stall_hs &&
                     (iso_mode || (!rx_err && toggle_ok(rx_data1, data_toggle)));
  assign accept    = pkt_valid && room;
  assign nak_ev    = pkt_valid && !room && !iso_mode;
  assign over_ev   = pkt_valid && !room && iso_mode;
  assign tog_adv   = accept && !iso_mode;

  assign auto_rel  = unld_done && rxrdy &&
                     autoclr_hit(autoclr, 16'(unld_len), 16'(max_pkt_size));
  assign pop       = flush_req || rel_req || auto_rel;

  usb_rx_slot_q #(.SLOTS(SLOTS)) u_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (accept),
    .push_err (rx_err),
    .pop      (pop),
    .cap      (slot_cap(dbl_buf)),
    .cnt      (cnt),
    .room     (room),
    .head_err (head_err),
    .head_new (head_new)
  );

  usb_rx_ep_csr u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .wdata      (reg_wdata),
    .rxrdy      (rxrdy),
    .stall_sent (stall_sent),
    .over_set   (over_ev),
    .stall_bit  (stall_bit),
    .stalled    (stalled),
    .over       (over),
    .clr_tog    (clr_tog),
    .flush_req  (flush_req),
    .rel_req    (rel_req)
  );

  usb_rx_ep_toggle u_tog (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_tog),
    .adv   (tog_adv),
    .tog   (data_toggle)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ep_irq      <= 1'b0;
      rx_nak      <= 1'b0;
      fifo_rd_rst <= 1'b0;
    end else begin
      ep_irq      <= head_new;
      rx_nak      <= nak_ev;
      fifo_rd_rst <= flush_req;
    end
  end

  always_comb begin
    reg_rdata            = 8'h00;
    reg_rdata[B_STALLED] = stalled;
    reg_rdata[B_STALL]   = stall_bit;
    reg_rdata[B_DATAERR] = iso_mode && rxrdy && head_err;
    reg_rdata[B_OVER]    = iso_mode && over;
    reg_rdata[B_FULL]    = cnt == slot_cap(dbl_buf);
    reg_rdata[B_RXRDY]   = rxrdy;
  end

endmodule

// File: rtl/usb_rx_ep_chk.sv
module usb_rx_ep_chk #(
  parameter int MAXP_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic              rx_pkt,
  input logic              stall_sent,
  input logic              unld_done,
  input logic [MAXP_W-1:0] unld_len,
  input logic [MAXP_W-1:0] max_pkt_size,
  input logic              autoclr,
  input logic              iso_mode,
  input logic              stall_hs,
  input logic              data_toggle,
  input logic              ep_irq,
  input logic              fifo_rd_rst
);

  AST_IRQ_HAS_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
    ep_irq |-> reg_rdata[0]);                                             // R2

  AST_SHORT_UNLOAD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (unld_done && reg_rdata[0] && !(autoclr && unld_len == max_pkt_size) &&
     !reg_wr && !rx_pkt) |=> reg_rdata[0]);                               // R3

  AST_IDLE_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[4] && !reg_rdata[0]) |=> !fifo_rd_rst);          // R6

  AST_DATAERR_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[3] |-> reg_rdata[0]);                                       // R7

  AST_OVER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (iso_mode && reg_rdata[2] && !(reg_wr && !reg_wdata[2]))
      |=> (!iso_mode || reg_rdata[2]));                                   // R8

  AST_STALL_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_hs && rx_pkt && !reg_wr && !unld_done) |=> !ep_irq);           // R9

  AST_STALLED_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    stall_sent |=> reg_rdata[6]);                                         // R10

  AST_CLRDT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[7]) |=> !data_toggle);                           // R11

  AST_FULL_HAS_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[1] |-> reg_rdata[0]);                                       // R12

endmodule

bind usb_rx_ep_ctrl usb_rx_ep_chk #(.MAXP_W(MAXP_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .rx_pkt       (rx_pkt),
  .stall_sent   (stall_sent),
  .unld_done    (unld_done),
  .unld_len     (unld_len),
  .max_pkt_size (max_pkt_size),
  .autoclr      (autoclr),
  .iso_mode     (iso_mode),
  .stall_hs     (stall_hs),
  .data_toggle  (data_toggle),
  .ep_irq       (ep_irq),
  .fifo_rd_rst  (fifo_rd_rst)
);

// File: tb/sim_usb_rx_ep_ctrl.sv
module sim_usb_rx_ep_ctrl;

  localparam int MAXP_W = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [7:0]        reg_wdata = 8'h00;
  logic [7:0]        reg_rdata;
  logic              rx_pkt = 1'b0, rx_err = 1'b0, rx_data1 = 1'b0;
  logic              stall_sent = 1'b0, unld_done = 1'b0;
  logic [MAXP_W-1:0] unld_len = '0;
  logic [MAXP_W-1:0] max_pkt_size = 11'd64;
  logic              autoclr = 1'b0, iso_mode = 1'b0, dbl_buf = 1'b0;
  logic              stall_hs, rx_nak, data_toggle, ep_irq, fifo_rd_rst;

  int checks = 0;
  int errors = 0;

  always #2 clk = !clk;

  usb_rx_ep_ctrl #(.MAXP_W(MAXP_W)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic send_pkt(input logic d1, input logic err);
    @(negedge clk); rx_pkt = 1'b1; rx_data1 = d1; rx_err = err;
    @(negedge clk); rx_pkt = 1'b0; rx_err = 1'b0;
  endtask

  task automatic unload(input logic [MAXP_W-1:0] n);
    @(negedge clk); unld_done = 1'b1; unld_len = n;
    @(negedge clk); unld_done = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reg", reg_rdata, 8'h00);
    chk("R1 toggle", data_toggle, 0);
    chk("R1 outs", {stall_hs, rx_nak, ep_irq, fifo_rd_rst}, 4'h0);
  endtask

  task automatic t_bulk_single;
    send_pkt(1'b0, 1'b0);
    chk("R2 rxrdy+R12 full", reg_rdata, 8'h03);
    chk("R2 irq", ep_irq, 1);
    chk("R11 toggle flips", data_toggle, 1);
    @(negedge clk);
    chk("R2 irq one cycle", ep_irq, 0);
    send_pkt(1'b1, 1'b0);
    chk("R13 nak", rx_nak, 1);
    chk("R13 not stored, no over", reg_rdata, 8'h03);
    chk("R13 toggle kept", data_toggle, 1);
    wr_reg(8'h01);
    chk("R4 write 1 no effect", reg_rdata, 8'h03);
    wr_reg(8'h00);
    chk("R4 manual release", reg_rdata, 8'h00);
  endtask

  task automatic t_toggle;
    send_pkt(1'b0, 1'b0);
    chk("R11 wrong toggle dropped", reg_rdata, 8'h00);
    chk("R11 toggle unchanged", data_toggle, 1);
    send_pkt(1'b1, 1'b1);
    chk("R11 bulk error dropped", reg_rdata, 8'h00);
    wr_reg(8'h81);
    chk("R11 clrdt", data_toggle, 0);
    chk("R11 clrdt reads 0", reg_rdata, 8'h00);
  endtask

  task automatic t_autoclr;
    autoclr = 1'b1;
    send_pkt(1'b0, 1'b0);
    unload(11'd10);
    chk("R3 short unload keeps", reg_rdata[0], 1);
    unload(11'd64);
    chk("R3 full unload releases", reg_rdata[0], 0);
    autoclr = 1'b0;
    send_pkt(1'b1, 1'b0);
    unload(11'd64);
    chk("R3 autoclr off keeps", reg_rdata[0], 1);
    wr_reg(8'h00);
  endtask

  task automatic t_double_flush;
    dbl_buf = 1'b1;
    send_pkt(1'b0, 1'b0);
    chk("R12 one of two not full", reg_rdata, 8'h01);
    send_pkt(1'b1, 1'b0);
    chk("R12 two of two full", reg_rdata, 8'h03);
    wr_reg(8'h11);
    chk("R5 flush pulse", fifo_rd_rst, 1);
    chk("R5 second packet ready", reg_rdata, 8'h01);
    chk("R5 irq re-raised", ep_irq, 1);
    wr_reg(8'h11);
    chk("R5 second flush empties", reg_rdata, 8'h00);
    wr_reg(8'h11);
    chk("R6 idle flush no pulse", fifo_rd_rst, 0);
    chk("R6 idle flush no change", reg_rdata, 8'h00);
    dbl_buf = 1'b0;
  endtask

  task automatic t_iso;
    iso_mode = 1'b1;
    send_pkt(1'b0, 1'b1);
    chk("R7 dataerr set", reg_rdata, 8'h0B);
    send_pkt(1'b0, 1'b0);
    chk("R8 overrun", reg_rdata, 8'h0F);
    wr_reg(8'h05);
    chk("R8 write 1 keeps over", reg_rdata, 8'h0F);
    iso_mode = 1'b0;
    #1;
    chk("R8 bulk masks err bits", reg_rdata, 8'h03);
    iso_mode = 1'b1;
    wr_reg(8'h01);
    chk("R8 over cleared", reg_rdata, 8'h0B);
    wr_reg(8'h00);
    chk("R7 dataerr follows rxrdy", reg_rdata, 8'h00);
    iso_mode = 1'b0;
  endtask

  task automatic t_stall;
    wr_reg(8'h21);
    chk("R9 stall handshake", stall_hs, 1);
    send_pkt(1'b1, 1'b0);
    chk("R9 not stored under stall", reg_rdata, 8'h20);
    @(negedge clk); stall_sent = 1'b1;
    @(negedge clk); stall_sent = 1'b0;
    chk("R10 stalled set", reg_rdata, 8'h60);
    wr_reg(8'h41);
    chk("R10 write 1 keeps stalled", reg_rdata, 8'h40);
    chk("R9 stall released", stall_hs, 0);
    wr_reg(8'h01);
    chk("R10 stalled cleared", reg_rdata, 8'h00);
    wr_reg(8'h21);
    iso_mode = 1'b1;
    #1;
    chk("R9 iso ignores stall", stall_hs, 0);
    iso_mode = 1'b0;
    wr_reg(8'h01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bulk_single();
    t_toggle();
    t_autoclr();
    t_double_flush();
    t_iso();
    t_stall();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule